// File: doc/BRIEF.md
# Transmit Inter-Frame Gap Controller

This block sits on the transmit side of a 10G Ethernet MAC and decides when the next frame may start. Each time the transmitter reports that a frame has ended, along with that frame's octet count, the block works out how many idle octets must follow. It then holds its ready output low until that many idle octets have gone out, at four octets per clock. The transmitter starts a new frame only while ready is high.

A single gap setting is read in one of two ways. In LAN mode it is a gap length in octets, taken in steps of four. Deficit idle counting lets the gap after each frame shrink or grow so that the next frame starts on a four-octet lane boundary, while the average gap stays at the programmed value. In WAN mode the setting is a stretch factor. On top of a fixed minimum gap, one extra idle octet is added for every (factor+1)*8 octets sent, and the remainder carries from one frame to the next. A larger factor therefore gives a shorter gap. Settings outside the legal range for the current mode are clamped. The mode and the setting are sampled only when a frame end is accepted.

Top module: `tx_ipg_ctrl`

## Requirements
- R1: After reset, `tx_ready` is 1, `gap_octets` is 0, and the LAN deficit and the WAN remainder are both 0.
- R2: A frame end is accepted when `frm_end` is 1 while `tx_ready` is 1. `tx_ready` is 0 from the next cycle on, for exactly ceil(G/4) cycles, where G is the gap computed for that frame. It is 1 again in the cycle after that.
- R3: In LAN mode (`cfg_wan`=0) the base gap B is `cfg_gap` rounded down to a multiple of 4 and then clamped to the range 8..100. A frame whose length is a multiple of 4 gets G = B.
- R4: In LAN mode, for a frame of length L, let e = L mod 4 and let D be the carried deficit (0..3). If e is 0, G = B. If D+e is 3 or less, G = B-e and D becomes D+e. Otherwise G = B+4-e and D becomes D+e-4. L+G is always a multiple of 4.
- R5: In WAN mode (`cfg_wan`=1), with ratio K = (S+1)*8 and carried remainder M, G = 12 + floor((L+M)/K), and M becomes (L+M) mod K.
- R6: In WAN mode the stretch factor S is `cfg_gap` clamped to the range 4..15.
- R7: A `frm_end` pulse while `tx_ready` is 0 is ignored. It does not change `gap_octets`, the length of the running gap, the deficit or the remainder.
- R8: Changes to `cfg_gap` or `cfg_wan` have no effect on a gap that is already running. They take effect from the next accepted frame end.
- R9: `gap_octets` shows the G of the most recently accepted frame and holds that value until the next accepted frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; four idle octets are sent per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gap | input | CFG_W (7) | Gap setting: octets in LAN mode, stretch factor in WAN mode |
| cfg_wan | input | 1 | Mode select: 1 = WAN, 0 = LAN |
| frm_end | input | 1 | One-cycle strobe marking the end of a transmitted frame |
| frm_len | input | LEN_W (14) | Octet count of the frame that is ending |
| tx_ready | output | 1 | The next frame may start |
| gap_octets | output | GAP_W (14) | Idle octets required after the last accepted frame |

## Verification
A frame end sampled at edge k loads `gap_octets` and drops `tx_ready` in the same edge. `tx_ready` then stays low through edge k+ceil(G/4)-1 and is high again after edge k+ceil(G/4). The bench drives inputs and samples outputs on the falling edge. For each accepted frame it pushes the expected G and the expected low-cycle count into a queue. A monitor counts the low samples of `tx_ready`, and at the first high sample it pops the queue and compares both the count and `gap_octets`. Ignored strobes and mid-gap setting changes push nothing, so any effect they had would show up as a mismatch on the gap that is running.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int LANE_OCT    = 4;
  localparam int LAN_MIN     = 8;
  localparam int LAN_MAX     = 100;
  localparam int WAN_MIN     = 4;
  localparam int WAN_MAX     = 15;
  localparam int WAN_MIN_GAP = 12;
  localparam int WAN_RATIO_MAX = (WAN_MAX + 1) * 8;

  // LAN base gap: step of four, clamped to the legal window
  function automatic int lan_base(input int v);
    int r;
    r = v - (v % LANE_OCT);
    if (r < LAN_MIN) r = LAN_MIN;
    else if (r > LAN_MAX) r = LAN_MAX;
    return r;
  endfunction

  // deficit-idle gap for a frame ending e octets past a lane boundary
  function automatic int dic_gap(input int b, input int e, input int d);
    if (e == 0) return b;
    if (d + e < LANE_OCT) return b - e;
    return b + LANE_OCT - e;
  endfunction

  function automatic int dic_next(input int e, input int d);
    if (e == 0) return d;
    if (d + e < LANE_OCT) return d + e;
    return d + e - LANE_OCT;
  endfunction

  // WAN ratio in octets per added idle octet
  function automatic int wan_ratio(input int v);
    int s;
    s = v;
    if (s < WAN_MIN) s = WAN_MIN;
    else if (s > WAN_MAX) s = WAN_MAX;
    return (s + 1) * 8;
  endfunction
endpackage

// File: rtl/ipg_lan_dic.sv
module ipg_lan_dic
  import ipg_pkg::*;
#(
  parameter int CFG_W = 7,
  parameter int LEN_W = 14,
  parameter int GAP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [CFG_W-1:0] cfg,
  input  logic [LEN_W-1:0] len,
  output logic [GAP_W-1:0] gap
);
  localparam int DEF_W = $clog2(LANE_OCT);

  logic [DEF_W-1:0] def_q;
  int               base_i;
  int               ofs_i;

  always_comb begin
    base_i = lan_base(int'(cfg));
    ofs_i  = int'(len) % LANE_OCT;
    gap    = GAP_W'(dic_gap(base_i, ofs_i, int'(def_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) def_q <= '0;
    else if (upd) def_q <= DEF_W'(dic_next(ofs_i, int'(def_q)));
  end

  // next start lands on a lane boundary
  p_lan_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ((int'(len) + int'(gap)) % LANE_OCT == 0));
  // gap stays within three octets of the clamped base
  p_lan_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (int'(gap) >= LAN_MIN - 3 && int'(gap) <= LAN_MAX + 3));
endmodule

// File: rtl/ipg_wan_stretch.sv
module ipg_wan_stretch
  import ipg_pkg::*;
#(
  parameter int CFG_W = 7,
  parameter int LEN_W = 14,
  parameter int GAP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [CFG_W-1:0] cfg,
  input  logic [LEN_W-1:0] len,
  output logic [GAP_W-1:0] gap
);
  localparam int REM_W = $clog2(WAN_RATIO_MAX);

  logic [REM_W-1:0] rem_q;
  int               tot_i;
  int               ratio_i;

  always_comb begin
    ratio_i = wan_ratio(int'(cfg));
    tot_i   = int'(len) + int'(rem_q);
    gap     = GAP_W'(WAN_MIN_GAP + tot_i / ratio_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else if (upd) rem_q <= REM_W'(tot_i % ratio_i);
  end

  p_wan_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> int'(gap) >= WAN_MIN_GAP);
  p_wan_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> int'(rem_q) < $past(ratio_i));
endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer
  import ipg_pkg::*;
#(
  parameter int GAP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             idle_done
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= gap;
    else if (cnt_q > GAP_W'(LANE_OCT)) cnt_q <= cnt_q - GAP_W'(LANE_OCT);
    else cnt_q <= '0;
  end

  assign idle_done = (cnt_q == '0);

  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load) |=> cnt_q < $past(cnt_q));
endmodule

// File: rtl/tx_ipg_ctrl.sv
module tx_ipg_ctrl
  import ipg_pkg::*;
#(
  parameter int CFG_W = 7,
  parameter int LEN_W = 14,
  parameter int GAP_W = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_gap,
  input  logic             cfg_wan,
  input  logic             frm_end,
  input  logic [LEN_W-1:0] frm_len,
  output logic             tx_ready,
  output logic [GAP_W-1:0] gap_octets
);
  logic             frm_acc;
  logic             lan_upd;
  logic             wan_upd;
  logic [GAP_W-1:0] lan_gap;
  logic [GAP_W-1:0] wan_gap;
  logic [GAP_W-1:0] gap_sel;

  assign frm_acc = frm_end && tx_ready;
  assign lan_upd = frm_acc && !cfg_wan;
  assign wan_upd = frm_acc && cfg_wan;
  assign gap_sel = cfg_wan ? wan_gap : lan_gap;

  ipg_lan_dic #(.CFG_W(CFG_W), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_lan (
    .clk(clk), .rst_n(rst_n), .upd(lan_upd), .cfg(cfg_gap), .len(frm_len), .gap(lan_gap)
  );

  ipg_wan_stretch #(.CFG_W(CFG_W), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_wan (
    .clk(clk), .rst_n(rst_n), .upd(wan_upd), .cfg(cfg_gap), .len(frm_len), .gap(wan_gap)
  );

  ipg_gap_timer #(.GAP_W(GAP_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(frm_acc), .gap(gap_sel), .idle_done(tx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) gap_octets <= '0;
    else if (frm_acc) gap_octets <= gap_sel;
  end

  p_end_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_acc |=> !tx_ready);
  p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_acc |=> $stable(gap_octets));
  p_ignored_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && !tx_ready) |=> !tx_ready || $stable(gap_octets));
endmodule

// File: tb/tx_ipg_ctrl_bench.sv
module tx_ipg_ctrl_bench;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_gap = 7'd12;
  logic        cfg_wan = 1'b0;
  logic        frm_end = 1'b0;
  logic [13:0] frm_len = '0;
  logic        tx_ready;
  logic [13:0] gap_octets;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { int gap; int low; string tag; } exp_t;
  exp_t q[$];

  int m_def = 0;
  int m_rem = 0;

  always #(CLK_PER/2) clk = ~clk;

  tx_ipg_ctrl u_tx_ipg_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .cfg_wan(cfg_wan),
    .frm_end(frm_end), .frm_len(frm_len), .tx_ready(tx_ready), .gap_octets(gap_octets)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference: expected gap from the requirements
  function automatic int model(input int len);
    int g;
    if (!cfg_wan) begin
      int b, e;
      b = (int'(cfg_gap) / 4) * 4;
      if (b < 8) b = 8;
      if (b > 100) b = 100;
      e = len % 4;
      if (e == 0) g = b;
      else if (m_def + e <= 3) begin g = b - e; m_def = m_def + e; end
      else begin g = b + (4 - e); m_def = m_def + e - 4; end
    end else begin
      int s, k, t;
      s = int'(cfg_gap);
      s = (s < 4) ? 4 : ((s > 15) ? 15 : s);
      k = 8 * (s + 1);
      t = len + m_rem;
      g = 12 + t / k;
      m_rem = t - (t / k) * k;
    end
    return g;
  endfunction

  task automatic send(input int len, input string tag);
    exp_t x;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    frm_len = 14'(len);
    frm_end = 1'b1;
    x.gap = model(len);
    x.low = (x.gap + 3) / 4;
    x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    frm_end = 1'b0;
  endtask

  // monitor: measures each low run of tx_ready and compares
  initial begin
    int low_run;
    bit was_low;
    exp_t x;
    low_run = 0;
    was_low = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!tx_ready) low_run++;
        else if (was_low) begin
          if (q.size() == 0) check("R7 unexpected gap", low_run, 0);
          else begin
            x = q.pop_front();
            check({x.tag, " gap"}, int'(gap_octets), x.gap);
            check("R2 low cycles", low_run, x.low);
          end
          low_run = 0;
        end
        was_low = !tx_ready;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(tx_ready), 1);
    check("R1 gap", int'(gap_octets), 0);

    // LAN default, deficit sequence
    send(64, "R3");
    send(65, "R4");
    send(66, "R4");
    send(65, "R4");
    send(67, "R4");
    send(1518, "R4");
    // LAN clamps and rounding
    cfg_gap = 7'd3;   send(64, "R3");
    cfg_gap = 7'd120; send(64, "R3");
    cfg_gap = 7'd13;  send(61, "R3");
    cfg_gap = 7'd100; send(63, "R4");
    cfg_gap = 7'd8;   send(63, "R4");
    for (int i = 0; i < 8; i++) send(60 + i * 7, "R4");

    // setting change during a running gap
    cfg_gap = 7'd12;
    send(100, "R8");
    @(negedge clk);
    cfg_gap = 7'd40;
    send(64, "R8");

    // ignored frame end during a gap
    send(200, "R7");
    @(negedge clk);
    frm_len = 14'd77;
    frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    send(65, "R7");

    // WAN mode
    cfg_wan = 1'b1;
    cfg_gap = 7'd12;
    send(1000, "R5");
    send(100, "R5");
    send(64, "R5");
    cfg_gap = 7'd2;   send(1500, "R6");
    cfg_gap = 7'd31;  send(1500, "R6");
    cfg_gap = 7'd15;  send(9000, "R5");
    // mode switch mid-gap; LAN deficit resumes
    send(500, "R8");
    @(negedge clk);
    cfg_wan = 1'b0;
    cfg_gap = 7'd12;
    send(66, "R8");
    send(66, "R4");

    @(negedge clk);
    while (q.size() != 0 || !tx_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule